// File: doc/BRIEF.md
# SMBus Register Slave with Block Access

This block is a serial-bus slave that holds a small bank of 8-bit control registers and drives the clock-enable controls of a larger chip from them. A host reaches the bank over a two-wire SMBus/I2C-compatible bus. It can write or read one register at a time, or move a run of registers in one block transfer. The block runs entirely in the system clock domain. It oversamples SCL and SDA through a short synchronizer and finds the bus events (start, stop, clock edges) from the sampled levels. It pulls SDA low through an open-drain enable. Clock stretching, arbitration and pad behaviour are outside the block.

Each transfer opens with the device address and a command byte. The top bit of the command picks single-register access, and the low seven bits then give the register offset. With the top bit clear, the transfer is a block transfer that starts at register 0. A block write normally carries a byte-count byte before its data, and a block read returns a count before its data. A control bit in register 0 drops that count phase in both directions. Every register returns to its power-up value on reset.

The register outputs are plain levels with no handshake, so they have no back-pressure. The serial side is paced only by the host's SCL, and the slave never holds the clock low.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte of D2h (write) or D3h (read), which is the 7-bit address 69h followed by the direction bit. It does not acknowledge any other address byte.
- R2: A command byte with bit 7 = 1 selects single-register access at the offset given by bits 6:0. One data byte then writes that register. After a repeated start and a read address, the slave returns that register.
- R3: A command byte with bit 7 = 0 selects a block write when register 0 bit 6 = 0. The next byte is a byte count, which is acknowledged and otherwise ignored. The data bytes after it are acknowledged and fill registers 0, 1, 2 and upward, and the host may stop after any whole byte.
- R4: When register 0 bit 6 = 1, a block write has no count byte: the first byte after the command goes to register 0. A block read in this mode returns register 0 as its first byte.
- R5: A block read returns first the count byte, equal to the bank size (16 = 10h). It then returns registers 0, 1, 2 and upward, each byte MSB first, for as long as the host acknowledges.
- R6: After the host answers a read byte with NACK, the slave releases SDA and does not drive it again until the next start.
- R7: After reset, register 0 reads 01h, register 1 reads F8h, and every other register reads 00h.
- R8: A write to an offset of 16 or more is acknowledged and discarded. A read of such an offset returns 00h.
- R9: A start or stop that arrives before a byte is complete aborts the transfer. The partial byte is never written.
- R10: The slave begins pulling SDA low only after a falling SCL edge. It releases SDA only after a falling SCL edge, a start or a stop.
- R11: After an address that does not match, the slave acknowledges no further byte until the next start.
- R12: `cfg_saved` equals register 0 bit 0. `src_en[4:0]` equals register 1 bits 7:3. `ctrl_regs[8*i+7:8*i]` holds register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_saved | output | 1 | Register 0 bit 0 (configuration-saved flag) |
| src_en | output | 5 | Register 1 bits 7:3, one enable per clock output, 1 = enabled |
| ctrl_regs | output | 128 | Whole register image, register i in bits 8i+7:8i |

## Verification
The risky collision is between bus-condition detection and the shift engine. A start or stop can land while a byte is half shifted, and it then races the byte-complete step that would commit a write. The bench provokes this by cutting a write byte after four bits with a repeated start, and another after three bits with a stop. It judges the result in two ways: the per-clock register-image comparison must never see the target register move, and a later single read must return its old value. A second collision, between the host's NACK and the slave loading the next read byte, is judged by SDA staying released after the NACK.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // transfer phase of the serial engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phase_e;

  // register 0 control bits
  localparam int CFG_SAVED_BIT = 0;
  localparam int CNT_SKIP_BIT  = 6;
  // register 1 enable field
  localparam int SRC_EN_LSB    = 3;
  localparam int SRC_EN_W      = 5;

  function automatic byte_t reset_value(input int idx);
    case (idx)
      0:       return 8'h01;
      1:       return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int ST = (STAGES < 2) ? 2 : STAGES;

  logic [ST-1:0] scl_pipe, sda_pipe;
  logic          scl_d, sda_d;
  logic          scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[ST-2:0], scl_i};
      sda_pipe <= {sda_pipe[ST-2:0], sda_i};
      scl_d    <= scl_pipe[ST-1];
      sda_d    <= sda_pipe[ST-1];
    end
  end

  assign scl_s     = scl_pipe[ST-1];
  assign sda_s     = sda_pipe[ST-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges only count as bus conditions while the clock is held high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_reg_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int PTR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_addr,
  input  byte_t                   wr_data,
  input  logic [PTR_W-1:0]        rd_addr,
  output byte_t                   rd_data,
  output logic [NREG*BYTE_W-1:0]  regs_flat
);

  localparam int AW = $clog2(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reset_value(g);
      else if (wr_en && (wr_addr == AW'(g)))
        q <= wr_data;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end

  // offsets past the bank read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == PTR_W'(i))
        rd_data = regs_flat[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 16,
  parameter int         PTR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sda_s,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic                    cnt_skip,
  input  byte_t                   rd_data,
  output logic [PTR_W-1:0]        rd_addr,
  output logic                    wr_en,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output byte_t                   wr_data,
  output logic                    sda_oe
);

  localparam int                AW       = $clog2(NREG);
  localparam logic [PTR_W-1:0]  NREG_P   = PTR_W'(NREG);
  localparam byte_t             CNT_BYTE = byte_t'(NREG);

  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic             in_ack;
  byte_t            shreg;
  byte_t            txsh;
  logic             rw;
  logic             byte_mode;
  logic             m_nack;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_next;

  assign ptr_next = (ptr == '1) ? ptr : ptr + 1'b1;
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      shreg     <= '0;
      txsh      <= '0;
      rw        <= 1'b0;
      byte_mode <= 1'b0;
      m_nack    <= 1'b0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (in_ack)
            m_nack <= sda_s;
          else if (bit_cnt < 4'd8) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            // end of the acknowledge slot: choose what the next byte is
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (rw) begin
                  phase <= PH_READ;
                  if (!byte_mode && !cnt_skip) begin
                    txsh   <= CNT_BYTE;
                    sda_oe <= ~CNT_BYTE[BYTE_W-1];
                  end else begin
                    txsh   <= rd_data;
                    sda_oe <= ~rd_data[BYTE_W-1];
                    ptr    <= ptr_next;
                  end
                end else begin
                  phase <= PH_CMD;
                end
              end
              PH_CMD: begin
                byte_mode <= shreg[7];
                ptr       <= shreg[7] ? PTR_W'(shreg[6:0]) : '0;
                phase     <= (shreg[7] || cnt_skip) ? PH_WRITE : PH_COUNT;
              end
              PH_COUNT: phase <= PH_WRITE;
              PH_READ: begin
                if (m_nack)
                  phase <= PH_IGNORE;
                else begin
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[BYTE_W-1];
                  ptr    <= ptr_next;
                end
              end
              default: ;
            endcase
          end else if (bit_cnt == 4'd8) begin
            // byte complete: enter the acknowledge slot
            in_ack <= 1'b1;
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  sda_oe <= 1'b0;
                  phase  <= PH_IGNORE;
                end
              end
              PH_CMD, PH_COUNT: sda_oe <= 1'b1;
              PH_WRITE: begin
                sda_oe <= 1'b1;
                if (ptr < NREG_P) begin
                  wr_en   <= 1'b1;
                  wr_addr <= AW'(ptr);
                  wr_data <= shreg;
                end
                ptr <= ptr_next;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (phase == PH_READ) begin
            // next transmit bit, MSB first
            txsh   <= {txsh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~txsh[BYTE_W-2];
          end
        end
      end
    end
  end

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic                   cfg_saved,
  output logic [SRC_EN_W-1:0]    src_en,
  output logic [NREG*BYTE_W-1:0] ctrl_regs
);

  localparam int AW    = $clog2(NREG);
  localparam int PTR_W = 8;

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  byte_t            wr_data, rd_data;
  logic [PTR_W-1:0] rd_addr;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .PTR_W(PTR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cnt_skip  (ctrl_regs[CNT_SKIP_BIT]),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  smb_reg_bank #(.NREG(NREG), .PTR_W(PTR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (ctrl_regs)
  );

  assign cfg_saved = ctrl_regs[CFG_SAVED_BIT];
  assign src_en    = ctrl_regs[BYTE_W + SRC_EN_LSB +: SRC_EN_W];

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int REG_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [REG_W-1:0] ctrl_regs
);

  // R10: the pull-down only starts after a falling clock edge
  a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R10: release only after a falling edge or a bus condition
  a_r10_release_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R6: a stop always leaves the line released
  a_r6_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9: a start aborts whatever was being driven
  a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R3: the register image moves only on a committed write
  a_r3_regs_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs) |-> $past(wr_en));

endmodule

bind smb_reg_slave smb_reg_slave_chk #(.REG_W(NREG*8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .ctrl_regs (ctrl_regs)
);

// File: tb/smb_reg_slave_test.sv
`timescale 1ns/1ps
module smb_reg_slave_test;

  localparam int NREG = 16;
  localparam int H    = 8;   // system clocks per SCL half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, cfg_saved;
  logic [4:0] src_en;
  logic [NREG*8-1:0] ctrl_regs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  smb_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_saved(cfg_saved), .src_en(src_en), .ctrl_regs(ctrl_regs)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural register model
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (m_scl) begin
        for (int i = 0; i < NREG; i++)
          check(ctrl_regs[i*8 +: 8] == model[i], "R12 register image",
                ctrl_regs[i*8 +: 8], model[i]);
        check(cfg_saved == model[0][0], "R12 cfg_saved", cfg_saved, model[0][0]);
        check(src_en == model[1][7:3], "R12 src_en", src_en, model[1][7:3]);
      end
      if (m_scl && prev_scl)
        check(sda_oe == prev_oe, "R10 SDA stable while SCL high", sda_oe, prev_oe);
      prev_oe  = sda_oe;
      prev_scl = m_scl;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(H);
    m_scl = 1'b1; idle(H);
    m_sda = 1'b0; idle(H);
    m_scl = 1'b0; idle(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(H);
    m_scl = 1'b1; idle(H);
    m_sda = 1'b1; idle(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; idle(H);
      m_scl = 1'b1; idle(H);
      m_scl = 1'b0; idle(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int wr_idx, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1;
    if (wr_idx >= 0 && wr_idx < NREG) model[wr_idx] = b;
    idle(H);
    m_scl = 1'b1; idle(H/2);
    ack = ~sda_line;
    idle(H/2);
    m_scl = 1'b0; idle(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      idle(H);
      m_scl = 1'b1; idle(H/2);
      b[i] = sda_line;
      idle(H/2);
      m_scl = 1'b0; idle(2);
    end
    m_sda = nack; idle(H);
    m_scl = 1'b1; idle(H);
    m_scl = 1'b0; idle(2);
    m_sda = 1'b1;
  endtask

  task automatic wr_single(input logic [6:0] off, input logic [7:0] data, input string tag);
    bit a;
    bus_start();
    send_byte(8'hD2, -1, a); check(a, "R1 write address ack", a, 1);
    send_byte({1'b1, off}, -1, a); check(a, {tag, " command ack"}, a, 1);
    send_byte(data, (off < NREG) ? int'(off) : -1, a); check(a, {tag, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic rd_single(input logic [6:0] off, input logic [7:0] exp, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, -1, a); check(a, "R1 write address ack", a, 1);
    send_byte({1'b1, off}, -1, a); check(a, {tag, " command ack"}, a, 1);
    bus_start();
    send_byte(8'hD3, -1, a); check(a, "R1 read address ack", a, 1);
    recv_byte(b, 1'b1);
    check(b == exp, tag, b, exp);
    idle(4);
    check(!sda_oe, "R6 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h01 : (i == 1) ? 8'hF8 : 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R7 reset image, R12 derived outputs
    for (int i = 0; i < NREG; i++)
      check(ctrl_regs[i*8 +: 8] == model[i], "R7 reset value", ctrl_regs[i*8 +: 8], model[i]);
    check(src_en == 5'h1F, "R12 src_en after reset", src_en, 5'h1F);
    check(cfg_saved == 1'b1, "R12 cfg_saved after reset", cfg_saved, 1);

    // R2 single write and read back
    wr_single(7'd5, 8'hA5, "R2");
    rd_single(7'd5, 8'hA5, "R2 single read");
    rd_single(7'd1, 8'hF8, "R7 register 1 read");

    // R1 / R11 foreign address
    bus_start();
    send_byte(8'hA0, -1, a); check(!a, "R1 foreign address not acked", a, 0);
    send_byte(8'h55, -1, a); check(!a, "R11 no ack after mismatch", a, 0);
    bus_stop();

    // R3 block write with count
    bus_start();
    send_byte(8'hD2, -1, a); check(a, "R1 address ack", a, 1);
    send_byte(8'h00, -1, a); check(a, "R3 block command ack", a, 1);
    send_byte(8'h03, -1, a); check(a, "R3 count ack", a, 1);
    send_byte(8'h11, 0, a);  check(a, "R3 data0 ack", a, 1);
    send_byte(8'h22, 1, a);  check(a, "R3 data1 ack", a, 1);
    send_byte(8'h33, 2, a);  check(a, "R3 data2 ack", a, 1);
    bus_stop();
    check(src_en == 5'h04, "R12 src_en follows register 1", src_en, 5'h04);

    // R5 block read with count
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a); check(a, "R1 read address ack", a, 1);
    recv_byte(b, 1'b0); check(b == 8'h10, "R5 count byte", b, 8'h10);
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, i == 3);
      check(b == model[i], "R5 sequential block read", b, model[i]);
    end
    idle(4);
    check(!sda_oe, "R6 released after NACK", sda_oe, 0);
    bus_stop();

    // R4 skip the count phase
    wr_single(7'd0, 8'h41, "R4");
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h41, 0, a); check(a, "R4 first data ack", a, 1);
    send_byte(8'h99, 1, a); check(a, "R4 second data ack", a, 1);
    bus_stop();
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a);
    recv_byte(b, 1'b0); check(b == 8'h41, "R4 block read starts at register 0", b, 8'h41);
    recv_byte(b, 1'b1); check(b == 8'h99, "R4 second block byte", b, 8'h99);
    bus_stop();

    // R8 offsets past the bank
    wr_single(7'h20, 8'h77, "R8");
    rd_single(7'h20, 8'h00, "R8 read past bank");

    // R9 aborts in mid-byte
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h8A, -1, a);
    send_bits(8'hEE, 4);
    bus_start();
    bus_stop();
    rd_single(7'd10, 8'h00, "R9 start mid-byte");
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h8B, -1, a);
    send_bits(8'hEE, 3);
    bus_stop();
    rd_single(7'd11, 8'h00, "R9 stop mid-byte");

    idle(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule